// File: doc/BRIEF.md
# USB Power-Area Enable Sequencer

This block brings the power area of a two-port USB PHY and its two USB channels up and down in a fixed order. It drives three kinds of control outputs: a power-ready line to the PHY with inverted sense, four clock enables and four module-stop bits. On the way up it drops power-ready, then switches the clocks on, then releases the module stops. The way down is the exact reverse. Each step is held for a programmable number of cycles before the next one is driven.

Two independent requesters share the area: the PHY port logic (requester 0) and the PHY control logic (requester 1). Each requester raises a one-cycle claim or release pulse and receives a one-cycle acknowledge when the request has taken effect. A saturating reference counter decides when the area must be up. The first claim starts a power-up and the last release starts a power-down. A sequence that has started always runs to its end. A claim that arrives during a power-down is served by a fresh power-up once the area has reached the off state.

Top module: `usbpd_seq`

## Requirements
- R1: After reset, `pwr_rdy` is 1, `clk_en` is 4'h0, `mod_stop` is 4'hF, and `ack` and `cnt_err` are 0.
- R2: When a claim at the sampling edge E1 moves the count from 0 to 1, with step delay D: `pwr_rdy` falls after edge E2, `clk_en` becomes 4'hF after edge E(D+3), and `mod_stop` becomes 4'h0 after edge E(2D+4).
- R3: When a release at E1 moves the count to 0 while the area is on: `mod_stop` becomes 4'hF after edge E2, `clk_en` becomes 4'h0 after edge E(D+3), and `pwr_rdy` rises after edge E(2D+4).
- R4: Every intermediate step lasts D+1 cycles. D is the `step_dly` value sampled when that step is entered, and D=0 gives one cycle.
- R5: A claim or release that leaves the count non-zero while the area is on changes no output. It is acknowledged one cycle after its sampling edge, after E2. Simultaneous first claims by both requesters start a single power-up.
- R6: Only the release that brings the count to 0 starts a power-down.
- R7: A claim that arrives during a power-down does not reverse it. The power-down completes, `pwr_rdy` is high for exactly one cycle, and then a full power-up follows.
- R8: A release that would take the count below zero pulses `cnt_err` for one cycle after E1. It leaves the count and all outputs unchanged and is not acknowledged.
- R9: `ack[i]` is a one-cycle pulse. For a request that runs a sequence, it is due after edge E(2D+5). For a request made during a sequence, it is due one cycle after the area reaches the state that the request needs.
- R10: All bits of `clk_en` switch together, and so do all bits of `mod_stop`. Clock bit 3 serves the PHY, bits 0 and 2 serve channel 0 and bit 1 serves channel 1. Stop bit 0 serves the PHY, bits 1 and 2 serve channel 0 and bit 3 serves channel 1.
- R11: A requester that asserts claim and release in the same cycle has no effect. The count, the outputs, `ack` and `cnt_err` do not change.
- R12: The count saturates at 2^CNT_W-1. With CNT_W=2, four claims followed by three releases power the area down on the third release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_dly | input | 16 | Extra cycles held in each intermediate step |
| claim_req | input | 2 | One-cycle claim pulse per requester (0 port logic, 1 control logic) |
| release_req | input | 2 | One-cycle release pulse per requester |
| ack | output | 2 | One-cycle acknowledge per requester |
| cnt_err | output | 1 | One-cycle pulse on a release at zero count |
| pwr_rdy | output | 1 | Power-ready, low while the area is powered |
| clk_en | output | 4 | Clock enables (see R10) |
| mod_stop | output | 4 | Module-stop bits, 1 = stopped (see R10) |

## Verification
Take the edge that samples a request as E1 and the step delay as D. Power-ready moves after E2, the clocks after E(D+3), the module stops after E(2D+4) and the acknowledge after E(2D+5). Acknowledges for requests that need no sequence, and the error pulse, are due after E2 and E1 respectively. Each test drives its pulse at a falling edge and samples every falling edge after that, recording the index of the first transition of each output. It then compares those indices with the values computed from D. In the pending case, a second pulse is injected at a chosen sample index and the up-sequence offsets are shifted by the cycle in which the off state is reached.

// File: rtl/usbpd_pkg.sv
package usbpd_pkg;

    localparam int N_REQ  = 2;
    localparam int N_CLK  = 4;
    localparam int N_STOP = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_UP_RDY,
        ST_UP_CLK,
        ST_ON,
        ST_DN_STOP,
        ST_DN_CLK
    } seq_st_e;

    typedef struct packed {
        logic rdy_hi;
        logic clk_on;
        logic stopped;
    } ctl_t;

    function automatic ctl_t decode_ctl(seq_st_e s);
        ctl_t c;
        c.rdy_hi  = (s == ST_OFF);
        c.clk_on  = (s == ST_UP_CLK) || (s == ST_ON) || (s == ST_DN_STOP);
        c.stopped = (s != ST_ON);
        return c;
    endfunction

endpackage

// File: rtl/usbpd_refcnt.sv
module usbpd_refcnt #(
    parameter int CNT_W = 2,
    parameter int N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] up,
    input  logic [N_REQ-1:0] dn,
    output logic             nz,
    output logic             accept,
    output logic             err
);
    localparam int EXT_W = CNT_W + $clog2(N_REQ + 1) + 1;
    localparam logic [EXT_W-1:0] MAX_EXT = EXT_W'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] n_up, n_dn, sum, nxt;

    always_comb begin
        n_up = '0;
        n_dn = '0;
        for (int i = 0; i < N_REQ; i++) begin
            n_up = n_up + EXT_W'(up[i]);
            n_dn = n_dn + EXT_W'(dn[i]);
        end
        sum    = EXT_W'(cnt) + n_up;
        accept = (sum >= n_dn);
        nxt    = sum - n_dn;
        if (nxt > MAX_EXT)
            nxt = MAX_EXT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            err <= !accept;
            if (accept)
                cnt <= nxt[CNT_W-1:0];
        end
    end

    assign nz = (cnt != '0);
endmodule

// File: rtl/usbpd_step_timer.sv
module usbpd_step_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    output logic             done
);
    logic [DLY_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= dly;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign done = (remain == '0);
endmodule

// File: rtl/usbpd_seq_fsm.sv
module usbpd_seq_fsm
    import usbpd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    want_on,
    input  logic    step_done,
    output seq_st_e st,
    output logic    load
);
    seq_st_e nxt;

    always_comb begin
        nxt  = st;
        load = 1'b0;
        case (st)
            ST_OFF:     if (want_on)    begin nxt = ST_UP_RDY;  load = 1'b1; end
            ST_UP_RDY:  if (step_done)  begin nxt = ST_UP_CLK;  load = 1'b1; end
            ST_UP_CLK:  if (step_done)        nxt = ST_ON;
            ST_ON:      if (!want_on)   begin nxt = ST_DN_STOP; load = 1'b1; end
            ST_DN_STOP: if (step_done)  begin nxt = ST_DN_CLK;  load = 1'b1; end
            ST_DN_CLK:  if (step_done)        nxt = ST_OFF;
            default:                          nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_OFF;
        else
            st <= nxt;
    end
endmodule

// File: rtl/usbpd_ack_gen.sv
module usbpd_ack_gen
    import usbpd_pkg::*;
#(
    parameter int N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] up,
    input  logic [N_REQ-1:0] dn,
    input  logic             accept,
    input  logic             want_on,
    input  seq_st_e          st,
    output logic [N_REQ-1:0] ack
);
    logic settled_on, at_off;

    assign settled_on = (st == ST_ON) && want_on;
    assign at_off     = (st == ST_OFF);

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        logic pend_up, pend_dn, fire_up, fire_dn;

        assign fire_up = pend_up && settled_on;
        assign fire_dn = pend_dn && (at_off || settled_on);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_up <= 1'b0;
                pend_dn <= 1'b0;
                ack[g]  <= 1'b0;
            end else begin
                ack[g] <= fire_up || fire_dn;
                if (accept && up[g])
                    pend_up <= 1'b1;
                else if ((accept && dn[g]) || fire_up)
                    pend_up <= 1'b0;
                if (accept && dn[g])
                    pend_dn <= 1'b1;
                else if (fire_dn)
                    pend_dn <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usbpd_seq.sv
module usbpd_seq
    import usbpd_pkg::*;
#(
    parameter int DLY_W = 16,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] step_dly,
    input  logic [N_REQ-1:0] claim_req,
    input  logic [N_REQ-1:0] release_req,
    output logic [N_REQ-1:0] ack,
    output logic             cnt_err,
    output logic             pwr_rdy,
    output logic [N_CLK-1:0] clk_en,
    output logic [N_STOP-1:0] mod_stop
);
    logic [N_REQ-1:0] eff_up, eff_dn;
    logic             want_on, accept, load, step_done;
    seq_st_e          st;
    ctl_t             ctl;

    // A requester pulsing both lines in one cycle is treated as idle.
    assign eff_up = claim_req & ~release_req;
    assign eff_dn = release_req & ~claim_req;

    usbpd_refcnt #(.CNT_W(CNT_W), .N_REQ(N_REQ)) u_cnt (
        .clk(clk), .rst(rst), .up(eff_up), .dn(eff_dn),
        .nz(want_on), .accept(accept), .err(cnt_err)
    );

    usbpd_step_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk(clk), .rst(rst), .load(load), .dly(step_dly), .done(step_done)
    );

    usbpd_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .want_on(want_on), .step_done(step_done),
        .st(st), .load(load)
    );

    usbpd_ack_gen #(.N_REQ(N_REQ)) u_ack (
        .clk(clk), .rst(rst), .up(eff_up), .dn(eff_dn), .accept(accept),
        .want_on(want_on), .st(st), .ack(ack)
    );

    assign ctl     = decode_ctl(st);
    assign pwr_rdy = ctl.rdy_hi;

    // The whole area switches as one unit; every owner bit follows the group.
    for (genvar c = 0; c < N_CLK; c++) begin : g_clk
        assign clk_en[c] = ctl.clk_on;
    end
    for (genvar s = 0; s < N_STOP; s++) begin : g_stop
        assign mod_stop[s] = ctl.stopped;
    end
endmodule

// File: rtl/usbpd_seq_chk.sv
module usbpd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ack,
    input logic       cnt_err,
    input logic       pwr_rdy,
    input logic [3:0] clk_en,
    input logic [3:0] mod_stop
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwr_rdy && clk_en == 4'h0 && mod_stop == 4'hF && ack == 2'b00 && !cnt_err));

    a_r2_clk_after_rdy: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en[3]) |-> $past(!pwr_rdy));

    a_r2_run_after_clk: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_stop[0]) |-> $past(clk_en[3]));

    a_r3_clk_off_after_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en[3]) |-> ($past(mod_stop[0]) && mod_stop[0]));

    a_r3_rdy_after_clk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_rdy) |-> ($past(clk_en) == 4'h0));

    a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
        (ack != 2'b00) |=> ((ack & $past(ack)) == 2'b00));

    a_r10_group_move: assert property (@(posedge clk) disable iff (rst)
        (clk_en == 4'h0 || clk_en == 4'hF) && (mod_stop == 4'h0 || mod_stop == 4'hF));
endmodule

bind usbpd_seq usbpd_seq_chk u_chk (
    .clk(clk), .rst(rst), .ack(ack), .cnt_err(cnt_err),
    .pwr_rdy(pwr_rdy), .clk_en(clk_en), .mod_stop(mod_stop)
);

// File: tb/usbpd_seq_bench.sv
module usbpd_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] step_dly = 16'd0;
    logic [1:0]  claim_req = 2'b00;
    logic [1:0]  release_req = 2'b00;
    logic [1:0]  ack;
    logic        cnt_err;
    logic        pwr_rdy;
    logic [3:0]  clk_en;
    logic [3:0]  mod_stop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int f_rdy_fall, f_rdy_rise, f_clk_rise, f_clk_fall, f_stop_fall, f_stop_rise;
    int f_ack0, f_ack1, n_ack0, n_ack1, f_err, n_err, bad_grp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usbpd_seq u_usbpd_seq (
        .clk(clk), .rst(rst), .step_dly(step_dly), .claim_req(claim_req),
        .release_req(release_req), .ack(ack), .cnt_err(cnt_err),
        .pwr_rdy(pwr_rdy), .clk_en(clk_en), .mod_stop(mod_stop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse already driven by caller at a falling edge; sample n falling edges.
    task automatic observe(input int n, input int m2, input logic [1:0] c2, input logic [1:0] r2);
        logic       p_rdy;
        logic [3:0] p_clk, p_stop;
        p_rdy = pwr_rdy; p_clk = clk_en; p_stop = mod_stop;
        f_rdy_fall = -1; f_rdy_rise = -1; f_clk_rise = -1; f_clk_fall = -1;
        f_stop_fall = -1; f_stop_rise = -1; f_ack0 = -1; f_ack1 = -1; f_err = -1;
        n_ack0 = 0; n_ack1 = 0; n_err = 0; bad_grp = 0;
        for (int m = 1; m <= n; m++) begin
            @(negedge clk);
            if (m == 1) begin claim_req = 2'b00; release_req = 2'b00; end
            if (m == m2 + 1) begin claim_req = 2'b00; release_req = 2'b00; end
            if (m == m2) begin claim_req = c2; release_req = r2; end
            if (p_rdy && !pwr_rdy && f_rdy_fall < 0) f_rdy_fall = m;
            if (!p_rdy && pwr_rdy && f_rdy_rise < 0) f_rdy_rise = m;
            if (p_clk == 4'h0 && clk_en != 4'h0 && f_clk_rise < 0) f_clk_rise = m;
            if (p_clk != 4'h0 && clk_en == 4'h0 && f_clk_fall < 0) f_clk_fall = m;
            if (p_stop != 4'h0 && mod_stop == 4'h0 && f_stop_fall < 0) f_stop_fall = m;
            if (p_stop == 4'h0 && mod_stop != 4'h0 && f_stop_rise < 0) f_stop_rise = m;
            if (ack[0]) begin n_ack0++; if (f_ack0 < 0) f_ack0 = m; end
            if (ack[1]) begin n_ack1++; if (f_ack1 < 0) f_ack1 = m; end
            if (cnt_err) begin n_err++; if (f_err < 0) f_err = m; end
            if (!(clk_en == 4'h0 || clk_en == 4'hF) || !(mod_stop == 4'h0 || mod_stop == 4'hF))
                bad_grp++;
            p_rdy = pwr_rdy; p_clk = clk_en; p_stop = mod_stop;
        end
    endtask

    task automatic pulse(input logic [1:0] c, input logic [1:0] r, input int d);
        @(negedge clk);
        step_dly = 16'(d);
        claim_req = c;
        release_req = r;
    endtask

    task automatic no_moves(input string req);
        chk(f_rdy_fall < 0 && f_rdy_rise < 0, req, f_rdy_fall + f_rdy_rise, -2);
        chk(f_clk_rise < 0 && f_clk_fall < 0 && f_stop_fall < 0 && f_stop_rise < 0,
            req, f_clk_rise + f_stop_fall, -2);
    endtask

    task automatic t_reset;
        chk(pwr_rdy == 1'b1, "R1 pwr_rdy", pwr_rdy, 1);
        chk(clk_en == 4'h0, "R1 clk_en", clk_en, 0);
        chk(mod_stop == 4'hF, "R1 mod_stop", mod_stop, 15);
        chk(ack == 2'b00 && !cnt_err, "R1 ack/err", {ack, cnt_err}, 0);
    endtask

    task automatic check_up(input int d, input string tag);
        chk(f_rdy_fall == 2, {tag, " R2 rdy fall"}, f_rdy_fall, 2);
        chk(f_clk_rise == d + 3, {tag, " R2 R4 clk on"}, f_clk_rise, d + 3);
        chk(f_stop_fall == 2 * d + 4, {tag, " R2 R4 stop clear"}, f_stop_fall, 2 * d + 4);
        chk(bad_grp == 0 && clk_en == 4'hF && mod_stop == 4'h0, {tag, " R10 groups"}, bad_grp, 0);
    endtask

    task automatic check_down(input int d, input string tag);
        chk(f_stop_rise == 2, {tag, " R3 stop set"}, f_stop_rise, 2);
        chk(f_clk_fall == d + 3, {tag, " R3 R4 clk off"}, f_clk_fall, d + 3);
        chk(f_rdy_rise == 2 * d + 4, {tag, " R3 R4 rdy rise"}, f_rdy_rise, 2 * d + 4);
        chk(bad_grp == 0 && clk_en == 4'h0 && mod_stop == 4'hF, {tag, " R10 groups"}, bad_grp, 0);
    endtask

    task automatic t_power_up;
        pulse(2'b01, 2'b00, 3);
        observe(14, 0, 2'b00, 2'b00);
        check_up(3, "up");
        chk(f_ack0 == 11 && n_ack0 == 1, "R9 up ack0", f_ack0, 11);
    endtask

    task automatic t_share;
        pulse(2'b10, 2'b00, 3);
        observe(5, 0, 2'b00, 2'b00);
        no_moves("R5 second claim");
        chk(f_ack1 == 2 && n_ack1 == 1, "R5 claim ack1", f_ack1, 2);
        pulse(2'b00, 2'b10, 3);
        observe(5, 0, 2'b00, 2'b00);
        no_moves("R5 R6 non-last release");
        chk(f_ack1 == 2 && n_ack1 == 1, "R5 release ack1", f_ack1, 2);
    endtask

    task automatic t_power_down;
        pulse(2'b00, 2'b01, 0);
        observe(8, 0, 2'b00, 2'b00);
        check_down(0, "down");
        chk(f_ack0 == 5 && n_ack0 == 1, "R6 R9 down ack0", f_ack0, 5);
    endtask

    task automatic t_underflow;
        pulse(2'b00, 2'b01, 0);
        observe(5, 0, 2'b00, 2'b00);
        chk(f_err == 1 && n_err == 1, "R8 err pulse", f_err, 1);
        no_moves("R8 outputs held");
        chk(n_ack0 == 0 && n_ack1 == 0, "R8 no ack", n_ack0 + n_ack1, 0);
        pulse(2'b01, 2'b00, 1);
        observe(9, 0, 2'b00, 2'b00);
        check_up(1, "R8 count kept");
        chk(f_ack0 == 7, "R8 ack after claim", f_ack0, 7);
    endtask

    task automatic t_pending;
        pulse(2'b00, 2'b01, 2);
        observe(20, 3, 2'b10, 2'b00);
        chk(f_stop_rise == 2 && f_clk_fall == 5, "R7 down runs", f_clk_fall, 5);
        chk(f_rdy_rise == 8 && f_rdy_fall == 9, "R7 one off cycle", f_rdy_fall, 9);
        chk(f_clk_rise == 12 && f_stop_fall == 15, "R7 up after off", f_stop_fall, 15);
        chk(f_ack0 == 9 && n_ack0 == 1, "R9 release ack at off", f_ack0, 9);
        chk(f_ack1 == 16 && n_ack1 == 1, "R7 R9 pending claim ack", f_ack1, 16);
    endtask

    task automatic t_both_same;
        pulse(2'b01, 2'b01, 0);
        observe(6, 0, 2'b00, 2'b00);
        no_moves("R11 claim+release");
        chk(n_ack0 == 0 && n_err == 0, "R11 no ack/err", n_ack0 + n_err, 0);
        pulse(2'b00, 2'b10, 0);
        observe(8, 0, 2'b00, 2'b00);
        check_down(0, "R11 count kept");
    endtask

    task automatic t_saturate;
        pulse(2'b01, 2'b00, 0);
        observe(8, 0, 2'b00, 2'b00);
        chk(f_ack0 == 5, "R12 first claim", f_ack0, 5);
        for (int k = 0; k < 3; k++) begin
            pulse(2'b01, 2'b00, 0);
            observe(4, 0, 2'b00, 2'b00);
            chk(f_ack0 == 2, "R12 extra claim ack", f_ack0, 2);
        end
        for (int k = 0; k < 2; k++) begin
            pulse(2'b00, 2'b01, 0);
            observe(4, 0, 2'b00, 2'b00);
            no_moves("R12 area held");
        end
        pulse(2'b00, 2'b01, 0);
        observe(8, 0, 2'b00, 2'b00);
        check_down(0, "R12 third release");
    endtask

    task automatic t_dual;
        pulse(2'b11, 2'b00, 1);
        observe(9, 0, 2'b00, 2'b00);
        check_up(1, "R5 dual");
        chk(f_ack0 == 7 && f_ack1 == 7 && n_ack0 == 1, "R5 dual acks", f_ack1, 7);
        pulse(2'b00, 2'b11, 1);
        observe(9, 0, 2'b00, 2'b00);
        check_down(1, "R6 dual");
        chk(f_ack0 == 7 && f_ack1 == 7, "R6 dual release acks", f_ack0, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_power_up();
        t_share();
        t_power_down();
        t_underflow();
        t_pending();
        t_both_same();
        t_saturate();
        t_dual();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule